// File: doc/BRIEF.md
# PLL divider search engine

This block picks divider settings for a pixel-clock synthesizer. The synthesizer produces `f_ref * n / m`. A request carries the wanted frequency, the reference frequency and the allowed band, all as unsigned integers in the same unit. The engine first clamps the wanted frequency into the band. It then walks the reference divider `m` upward. For each `m` it finds the nearest feedback divider `n` and keeps the pair whose output lies closest to the clamped target.

Each `m` costs one pass of an iterative restoring divider. When the walk ends, the same divider computes the achieved frequency. The winning pair is then packed into the three register bytes the synthesizer takes. The N and P bytes are packed differently for each chip variant. Reference divisors above half the range are encoded as a halved value plus a divide-by-two flag.

A search starts with a one-cycle `start`. The search ends with a one-cycle `done`, and the results stay on the outputs until the next `done`. If no divider pair is usable, `err` is raised instead.

Top module: `pll_divider_search`

## Requirements
- R1: At `start` the target f is formed in two steps. If `req_freq < min_freq`, f becomes `min_freq`. Then, if the result exceeds `max_freq`, f becomes `max_freq`. When the band is inverted, `max_freq` therefore wins.
- R2: `variant` selects the limits. Value 0 gives m in 1..32 and n in 1..128. Value 1 gives m in 1..64 and n in 1..128. Values 2 and 3 give m in 1..64 and n in 1..2048.
- R3: For each tried m, n = floor((2·f·m + ref_freq) / (2·ref_freq)), which is nearest with halves rounded up. A candidate whose n lies outside 1..n_max is dropped.
- R4: An m above m_max/2 is tried only when it is even.
- R5: The error of a candidate is |f·m − ref_freq·n| / m. A candidate replaces the stored best only if its error is strictly smaller, so on a tie the smaller m is kept.
- R6: If best m ≤ m_max/2, `m_byte` = m−1 and the divide-by-two flag is 0. Otherwise `m_byte` = m/2−1 and the flag is 1. In both cases `m_byte` is below 32.
- R7: For variants 0 and 1, `n_byte` bit 7 is the flag and bits 6..0 are bits 6..0 of n−1. `p_byte` is 0.
- R8: For variants 2 and 3, `n_byte` is bits 7..0 of n−1. `p_byte` bit 7 is the flag, bits 6..4 are bits 10..8 of n−1, and bits 3..0 are 0.
- R9: `achieved_freq` = floor(ref_freq·n / m) for the chosen pair.
- R10: `done` is high for exactly one cycle per search. All result outputs, `err` included, change only in a `done` cycle and hold their values otherwise.
- R11: If no candidate survives, `done` comes with `err` = 1, and `achieved_freq`, `m_byte`, `n_byte` and `p_byte` are all 0.
- R12: A `start` while a search is running is ignored. A `start` in the `done` cycle begins a new search.
- R13: While reset is held, `done`, `err` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; all request inputs are sampled with it |
| req_freq | input | FREQ_W | Wanted output frequency |
| ref_freq | input | FREQ_W | Reference frequency, must be nonzero |
| min_freq | input | FREQ_W | Lower clamp for the target |
| max_freq | input | FREQ_W | Upper clamp for the target |
| variant | input | 2 | Chip variant selecting the limits and the packing |
| done | output | 1 | One-cycle pulse when the results are updated |
| err | output | 1 | No usable divider pair was found |
| achieved_freq | output | FREQ_W+1 | Frequency given by the chosen pair |
| m_byte | output | 8 | Packed reference divider |
| n_byte | output | 8 | Packed feedback divider |
| p_byte | output | 8 | Packed high feedback bits and divide-by-two flag |

## Verification
Two events can fall in the same cycle: the `done` pulse of one search and the `start` of the next. The bench provokes this by watching for `done` and raising `start` with fresh inputs in that same cycle. It then expects both of the following. First, the first result is presented and held, unchanged, through the whole second run. Second, the second run later delivers its own result. A separate case pulses `start` with different inputs in the middle of a run and expects only the first request's result. A reference model recomputes the clamp, the divider walk and the packing from the requirements, and the bench compares the outputs on every clock.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    localparam int M_MAX_SMALL = 32;
    localparam int M_MAX_LARGE = 64;
    localparam int N_MAX_SMALL = 128;
    localparam int N_MAX_LARGE = 2048;

    // m counts one past its limit before the walk ends
    localparam int M_W = $clog2(M_MAX_LARGE + 2);
    localparam int N_W = $clog2(N_MAX_LARGE + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_WAIT_N,
        ST_EVAL,
        ST_WAIT_F
    } eng_state_e;

    // largest reference divider for a variant
    function automatic logic [M_W-1:0] m_limit(input logic [1:0] sel);
        return (sel == 2'd0) ? M_W'(M_MAX_SMALL) : M_W'(M_MAX_LARGE);
    endfunction

    // largest feedback divider for a variant
    function automatic logic [N_W-1:0] n_limit(input logic [1:0] sel);
        return sel[1] ? N_W'(N_MAX_LARGE) : N_W'(N_MAX_SMALL);
    endfunction

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         valid,
    output logic [W-1:0] quo
);

    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     den;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             valid;
    } div_state_t;

    div_state_t q, d;
    logic [W:0] shifted;
    logic       fits;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        shifted = {q.rem, q.quo[W-1]};
        fits    = shifted >= {1'b0, q.den};
        if (load) begin
            d.rem  = '0;
            d.quo  = num;
            d.den  = den;
            d.cnt  = CNT_W'(W);
            d.busy = 1'b1;
        end else if (q.busy) begin
            // one quotient bit per cycle, most significant first
            d.rem = fits ? W'(shifted - {1'b0, q.den}) : shifted[W-1:0];
            d.quo = {q.quo[W-2:0], fits};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy  = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.valid;
    assign quo   = q.quo;

endmodule

// File: rtl/pll_reg_pack.sv
module pll_reg_pack
    import pll_search_pkg::*;
(
    input  logic [1:0]     sel,
    input  logic [M_W-1:0] best_m,
    input  logic [N_W-1:0] best_n,
    output logic [7:0]     m_byte,
    output logic [7:0]     n_byte,
    output logic [7:0]     p_byte
);

    logic [M_W-1:0] half;
    logic           upper;
    logic [M_W-1:0] m_enc;
    logic [10:0]    n_less;

    always_comb begin
        half   = m_limit(sel) >> 1;
        upper  = best_m > half;
        // the halved divisor goes with the divide-by-two flag
        m_enc  = upper ? (best_m >> 1) - M_W'(1) : best_m - M_W'(1);
        m_byte = 8'(m_enc);
        n_less = 11'(best_n - N_W'(1));
        if (sel[1]) begin
            n_byte = n_less[7:0];
            p_byte = {upper, n_less[10:8], 4'b0000};
        end else begin
            n_byte = {upper, n_less[6:0]};
            p_byte = 8'h00;
        end
    end

endmodule

// File: rtl/pll_divider_search.sv
module pll_divider_search
    import pll_search_pkg::*;
#(
    parameter int FREQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_freq,
    input  logic [FREQ_W-1:0] ref_freq,
    input  logic [FREQ_W-1:0] min_freq,
    input  logic [FREQ_W-1:0] max_freq,
    input  logic [1:0]        variant,
    output logic              done,
    output logic              err,
    output logic [FREQ_W:0]   achieved_freq,
    output logic [7:0]        m_byte,
    output logic [7:0]        n_byte,
    output logic [7:0]        p_byte
);

    localparam int NUM_W = FREQ_W + N_W;
    localparam int ERR_W = NUM_W + M_W;
    localparam int OUT_W = FREQ_W + 1;

    typedef struct packed {
        eng_state_e        st;
        logic [FREQ_W-1:0] f;
        logic [FREQ_W-1:0] rf;
        logic [1:0]        sel;
        logic [M_W-1:0]    m;
        logic [N_W-1:0]    n;
        logic              n_ok;
        logic              found;
        logic [M_W-1:0]    best_m;
        logic [N_W-1:0]    best_n;
        logic [NUM_W-1:0]  best_e;
        logic              done;
        logic              err;
        logic [OUT_W-1:0]  freq_out;
        logic [7:0]        mb;
        logic [7:0]        nb;
        logic [7:0]        pb;
    } eng_t;

    eng_t q, d;

    logic             div_load;
    logic [NUM_W-1:0] div_num;
    logic [NUM_W-1:0] div_den;
    logic             div_valid;
    logic [NUM_W-1:0] div_quo;

    logic [7:0] pk_m, pk_n, pk_p;

    logic [FREQ_W-1:0] clamp_lo, clamped;
    logic [M_W-1:0]    m_lim;
    logic [N_W-1:0]    n_lim;
    logic [NUM_W-1:0]  f_times_m;
    logic [NUM_W-1:0]  ref_times_n;
    logic [NUM_W-1:0]  e_new;
    logic [ERR_W-1:0]  lhs, rhs;

    pll_restoring_div #(.W(NUM_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .num   (div_num),
        .den   (div_den),
        .valid (div_valid),
        .quo   (div_quo)
    );

    pll_reg_pack u_pack (
        .sel    (q.sel),
        .best_m (q.best_m),
        .best_n (q.best_n),
        .m_byte (pk_m),
        .n_byte (pk_n),
        .p_byte (pk_p)
    );

    // shared arithmetic for the current candidate
    always_comb begin
        clamp_lo    = (req_freq < min_freq) ? min_freq : req_freq;
        clamped     = (clamp_lo > max_freq) ? max_freq : clamp_lo;
        m_lim       = m_limit(q.sel);
        n_lim       = n_limit(q.sel);
        f_times_m   = NUM_W'(q.f) * NUM_W'(q.m);
        ref_times_n = NUM_W'(q.rf) * NUM_W'(q.n);
        e_new       = (f_times_m >= ref_times_n) ? f_times_m - ref_times_n
                                                 : ref_times_n - f_times_m;
        // compare e_new/m against best_e/best_m without dividing
        lhs         = ERR_W'(e_new) * ERR_W'(q.best_m);
        rhs         = ERR_W'(q.best_e) * ERR_W'(q.m);
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        div_load = 1'b0;
        div_num  = '0;
        div_den  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.f      = clamped;
                    d.rf     = ref_freq;
                    d.sel    = variant;
                    d.m      = M_W'(1);
                    d.found  = 1'b0;
                    d.best_m = '0;
                    d.best_n = '0;
                    d.best_e = '0;
                    d.st     = ST_PICK;
                end
            end
            ST_PICK: begin
                if (q.m > m_lim) begin
                    if (q.found) begin
                        div_load = 1'b1;
                        div_num  = NUM_W'(q.rf) * NUM_W'(q.best_n);
                        div_den  = NUM_W'(q.best_m);
                        d.st     = ST_WAIT_F;
                    end else begin
                        d.done     = 1'b1;
                        d.err      = 1'b1;
                        d.freq_out = '0;
                        d.mb       = '0;
                        d.nb       = '0;
                        d.pb       = '0;
                        d.st       = ST_IDLE;
                    end
                end else if ((q.m > (m_lim >> 1)) && q.m[0]) begin
                    d.m = q.m + M_W'(1);
                end else begin
                    div_load = 1'b1;
                    div_num  = (f_times_m << 1) + NUM_W'(q.rf);
                    div_den  = NUM_W'(q.rf) << 1;
                    d.st     = ST_WAIT_N;
                end
            end
            ST_WAIT_N: begin
                if (div_valid) begin
                    d.n_ok = (div_quo != '0) && (div_quo <= NUM_W'(n_lim));
                    d.n    = div_quo[N_W-1:0];
                    d.st   = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (q.n_ok && (!q.found || (lhs < rhs))) begin
                    d.found  = 1'b1;
                    d.best_m = q.m;
                    d.best_n = q.n;
                    d.best_e = e_new;
                end
                d.m  = q.m + M_W'(1);
                d.st = ST_PICK;
            end
            ST_WAIT_F: begin
                if (div_valid) begin
                    d.freq_out = div_quo[OUT_W-1:0];
                    d.mb       = pk_m;
                    d.nb       = pk_n;
                    d.pb       = pk_p;
                    d.err      = 1'b0;
                    d.done     = 1'b1;
                    d.st       = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done          = q.done;
    assign err           = q.err;
    assign achieved_freq = q.freq_out;
    assign m_byte        = q.mb;
    assign n_byte        = q.nb;
    assign p_byte        = q.pb;

endmodule

// File: rtl/pll_divider_search_chk.sv
module pll_divider_search_chk #(
    parameter int OUT_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             err,
    input logic [OUT_W-1:0] achieved_freq,
    input logic [7:0]       m_byte,
    input logic [7:0]       n_byte,
    input logic [7:0]       p_byte
);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(achieved_freq) && $stable(m_byte) && $stable(n_byte)
                   && $stable(p_byte) && $stable(err)));

    assert_err_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (achieved_freq == '0 && m_byte == 8'h00
                           && n_byte == 8'h00 && p_byte == 8'h00));

    assert_m_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (m_byte < 8'd32));

    assert_p_low_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (p_byte[3:0] == 4'h0));

endmodule

bind pll_divider_search pll_divider_search_chk #(.OUT_W(FREQ_W + 1)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .err           (err),
    .achieved_freq (achieved_freq),
    .m_byte        (m_byte),
    .n_byte        (n_byte),
    .p_byte        (p_byte)
);

// File: tb/pll_divider_search_test.sv
module pll_divider_search_test;

    localparam int FW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, start, done, err;
    logic [FW-1:0] req_freq, ref_freq, min_freq, max_freq;
    logic [1:0]    variant;
    logic [FW:0]   achieved_freq;
    logic [7:0]    m_byte, n_byte, p_byte;

    pll_divider_search #(.FREQ_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_freq(req_freq), .ref_freq(ref_freq),
        .min_freq(min_freq), .max_freq(max_freq), .variant(variant),
        .done(done), .err(err), .achieved_freq(achieved_freq),
        .m_byte(m_byte), .n_byte(n_byte), .p_byte(p_byte)
    );

    typedef struct {
        int    freq;
        int    mb;
        int    nb;
        int    pb;
        bit    err;
        string tag;
    } exp_t;

    exp_t pend[$];
    exp_t held;
    bit   armed = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural model of one search, straight from the requirements
    function automatic exp_t model(input int req, input int rf, input int mn,
                                   input int mx, input int v, input string tag);
        exp_t   r;
        longint f, n, e, be, bm, bn;
        int     mmax, nmax, menc, nm1;
        bit     found, up;
        f = req;
        if (f < mn) f = mn;
        if (f > mx) f = mx;
        mmax = (v == 0) ? 32 : 64;
        nmax = (v >= 2) ? 2048 : 128;
        found = 0; be = 0; bm = 0; bn = 0;
        for (int m = 1; m <= mmax; m++) begin
            if (m > mmax / 2 && (m % 2) == 1) continue;
            n = (2 * f * m + rf) / (2 * rf);
            if (n < 1 || n > nmax) continue;
            e = f * m - rf * n;
            if (e < 0) e = -e;
            if (!found || e * bm < be * m) begin
                found = 1; be = e; bm = m; bn = n;
            end
        end
        r.tag = tag;
        if (!found) begin
            r.err = 1; r.freq = 0; r.mb = 0; r.nb = 0; r.pb = 0;
            return r;
        end
        r.err  = 0;
        r.freq = int'((rf * bn / bm) & 'h1FFFF);
        up     = bm > mmax / 2;
        menc   = up ? int'(bm / 2 - 1) : int'(bm - 1);
        nm1    = int'(bn - 1);
        r.mb   = menc;
        if (v >= 2) begin
            r.nb = nm1 & 255;
            r.pb = (int'(up) << 7) | (((nm1 >> 8) & 7) << 4);
        end else begin
            r.nb = (int'(up) << 7) | (nm1 & 127);
            r.pb = 0;
        end
        return r;
    endfunction

    // compare on every clock: new result on done, held values otherwise
    always @(negedge clk) begin
        if (armed) begin
            if (done) begin
                if (pend.size() == 0) begin
                    check(1'b0, "R10", "done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = pend.pop_front();
                    check(err == e.err, {e.tag, " R11"}, "err", int'(err), int'(e.err));
                    check(int'(achieved_freq) == e.freq, {e.tag, " R9"}, "freq",
                          int'(achieved_freq), e.freq);
                    check(int'(m_byte) == e.mb, {e.tag, " R6"}, "m_byte", int'(m_byte), e.mb);
                    check(int'(n_byte) == e.nb, {e.tag, " R7/R8"}, "n_byte", int'(n_byte), e.nb);
                    check(int'(p_byte) == e.pb, {e.tag, " R7/R8"}, "p_byte", int'(p_byte), e.pb);
                    held = e;
                end
            end else begin
                check(int'(achieved_freq) == held.freq && int'(m_byte) == held.mb
                      && int'(n_byte) == held.nb && int'(p_byte) == held.pb
                      && err == held.err, "R10", "held outputs",
                      int'(achieved_freq), held.freq);
            end
        end
    end

    task automatic launch(input int req, input int rf, input int mn, input int mx,
                          input int v, input string tag);
        @(negedge clk);
        req_freq = FW'(req); ref_freq = FW'(rf);
        min_freq = FW'(mn);  max_freq = FW'(mx);
        variant  = 2'(v);
        start    = 1'b1;
        pend.push_back(model(req, rf, mn, mx, v, tag));
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        while (pend.size() != 0 && k < 10000) begin
            @(negedge clk);
            #1;
            k++;
        end
        if (pend.size() != 0) begin
            check(1'b0, tag, "no done", 0, 1);
            pend.delete();
        end
    endtask

    task automatic run(input int req, input int rf, input int mn, input int mx,
                       input int v, input string tag);
        launch(req, rf, mn, mx, v, tag);
        wait_done(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0;
        req_freq = '0; ref_freq = '0; min_freq = '0; max_freq = '0; variant = '0;
        held = '{0, 0, 0, 0, 1'b0, "reset"};
        repeat (3) @(negedge clk);
        check(!done && !err && achieved_freq == '0 && m_byte == 8'h00
              && n_byte == 8'h00 && p_byte == 8'h00, "R13", "reset outputs",
              int'(done) + int'(err) + int'(m_byte), 0);
        rst_n = 1'b1;
        armed = 1'b1;

        // exact at m=1, so later exact m lose the tie; n above 255 uses P
        run(30000, 100, 1000, 60000, 2, "R5 R8 exact tie");
        // exact only at m=34, an even upper-half divisor
        run(500, 3400, 100, 60000, 1, "R4 R6 upper half");
        run(25175, 14318, 1000, 60000, 0, "R7 oldest");
        run(10, 14318, 20000, 50000, 1, "R1 clamp low");
        run(65000, 14318, 1000, 40000, 2, "R1 clamp high");
        run(100, 14318, 50000, 30000, 3, "R1 inverted band");
        // n rounds to 0 for every m
        run(1, 1000, 0, 65535, 0, "R3 R11 n zero");
        // n far above the limit for every m
        run(60000, 1, 0, 65535, 1, "R2 R11 n huge");
        // same request, narrow and wide n limit
        run(30000, 100, 0, 65535, 0, "R2 narrow n");
        run(30000, 100, 0, 65535, 3, "R2 wide n");

        for (int i = 0; i < 8; i++) begin
            run(3000 + (i * 7919) % 60000, 500 + (i * 4099) % 20000, 2000, 62000,
                i % 4, "R3 R5 R9 sweep");
        end

        // start in the middle of a run must be ignored
        launch(40000, 27000, 1000, 60000, 2, "R12 busy start");
        repeat (200) @(negedge clk);
        req_freq = 16'd1234; ref_freq = 16'd77; variant = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R12 busy start");

        // start in the done cycle must begin the next run
        launch(31500, 14318, 1000, 60000, 1, "R12 first of pair");
        begin
            int k = 0;
            while (k < 10000) begin
                @(negedge clk);
                k++;
                if (done) begin
                    req_freq = 16'd48000; ref_freq = 16'd2700;
                    min_freq = 16'd1000;  max_freq = 16'd60000;
                    variant  = 2'd2;
                    start    = 1'b1;
                    pend.push_back(model(48000, 2700, 1000, 60000, 2,
                                         "R12 start on done"));
                    break;
                end
            end
        end
        @(negedge clk);
        start = 1'b0;
        wait_done("R12 start on done");

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule